// File: doc/BRIEF.md
# Dual-Mode Fractional/Integer Multiplier

This block is the product stage of a 16-bit signal-processing datapath. It takes two 16-bit operands, each with its own signed/unsigned flag, widens both to 17 bits and multiplies them in one 17x17 signed array. Signed, unsigned and mixed-sign products therefore all use the same hardware. A scaler behind the array produces either a plain integer product or a Q31 fractional product, which is the Q15 product doubled. The result is sign-extended to 40 bits so that it can go straight into an accumulator. A byte mode multiplies only the low bytes of the operands and delivers a 16-bit result.

The result is registered. The register loads whenever `mul_en` is high, and the output is valid one clock later. When `mul_en` is low the register holds its value. Instruction decode, the register file and the accumulator are outside this block.

Top module: `dmul_unit`

## Requirements
- R1: In word mode a signed operand is widened to 17 bits by copying its bit 15. An unsigned operand is widened with a zero in bit 16.
- R2: In word integer mode (`frac_sel`=0, `byte_sel`=0), `acc_out` is the 33-bit product of the two widened operands, sign-extended from bit 32 to 40 bits.
- R3: Mixed-sign pairs produce the correct two's complement product in both integer and fractional word modes. In a mixed-sign pair one operand is signed and the other is unsigned.
- R4: In fractional word mode the 33-bit scaler output is the array product shifted left by one bit, with a zero entering the LSB. The scaler output is then sign-extended to 40 bits.
- R5: In fractional word mode, when both operands are signed and both equal 0x8000, `acc_out` is 40'h00_7FFF_FFFF. When both operands are 0x8000 but unsigned, there is no saturation.
- R6: In byte mode (`byte_sel`=1), `acc_out[15:0]` holds the product of the two widened low bytes and `acc_out[39:16]` is zero. `frac_sel` has no effect in byte mode.
- R7: In byte mode only bits 7:0 of each operand are used. Bit 7 is the sign for a signed operand. Bits 15:8 of the operands have no effect.
- R8: `acc_vld` is `mul_en` delayed by one clock, and `acc_out` shows the result of the operands presented with that `mul_en`.
- R9: While `mul_en` is low, `acc_out` keeps its previous value whatever the other inputs do.
- R10: While reset is asserted, `acc_vld` is 0 and `acc_out` is zero. Asserting `rst_n` clears both at once, without waiting for a clock edge.
- R11: In every word-mode result, bits 39:33 of `acc_out` equal bit 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| mul_en | input | 1 | Load enable: capture a new product on this edge |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| a_is_signed | input | 1 | 1: treat `opnd_a` as two's complement |
| b_is_signed | input | 1 | 1: treat `opnd_b` as two's complement |
| frac_sel | input | 1 | 1: fractional (Q31) scaling, 0: integer |
| byte_sel | input | 1 | 1: byte operands with a 16-bit result |
| acc_vld | output | 1 | Result valid (one cycle after `mul_en`) |
| acc_out | output | 40 | Sign-extended product |

## Verification
The hardest case to reach is the single fractional input pair that overflows Q31. It occurs only when both operands are 0x8000 and both are flagged signed in word mode. The stimulus table therefore places that pair next to its near misses:
- the same bit patterns flagged unsigned, which must not saturate;
- 0x7FFF squared, the largest legal product;
- the same operands in byte mode, where fractional scaling is ignored.

Mixed-sign vectors pair a signed 0x8000 with an unsigned 0xFFFF. This case checks that the extra 17th bit carries the full unsigned magnitude and does not turn it negative.

// File: rtl/dmul_pkg.sv
package dmul_pkg;

  // Operand width of the datapath and derived widths
  localparam int unsigned OP_W   = 16;
  localparam int unsigned EXT_W  = OP_W + 1;        // widened operand
  localparam int unsigned PROD_W = 2 * OP_W + 1;    // array/scaler output
  localparam int unsigned ACC_W  = 40;              // accumulator width
  localparam int unsigned BYTE_W = OP_W / 2;        // byte operand width

  typedef logic [OP_W-1:0]   opnd_t;
  typedef logic [EXT_W-1:0]  ext_t;
  typedef logic [PROD_W-1:0] prod_t;
  typedef logic [ACC_W-1:0]  acc_t;

endpackage

// File: rtl/dmul_opext.sv
module dmul_opext
  import dmul_pkg::*;
#(
  parameter int unsigned IN_W  = OP_W,
  parameter int unsigned OUT_W = IN_W + 1,
  parameter int unsigned LO_W  = IN_W / 2
) (
  input  logic [IN_W-1:0]  op_i,
  input  logic             signed_i,
  input  logic             byte_i,
  output logic [OUT_W-1:0] ext_o
);

  localparam int unsigned PAD_BYTE = OUT_W - LO_W;
  localparam int unsigned PAD_WORD = OUT_W - IN_W;

  logic fill_byte;
  logic fill_word;

  // The fill bit is the operand's top bit when it is signed, else zero
  assign fill_byte = signed_i & op_i[LO_W-1];
  assign fill_word = signed_i & op_i[IN_W-1];

  always_comb begin
    if (byte_i) begin
      ext_o = {{PAD_BYTE{fill_byte}}, op_i[LO_W-1:0]};
    end else begin
      ext_o = {{PAD_WORD{fill_word}}, op_i};
    end
  end

endmodule

// File: rtl/dmul_array.sv
module dmul_array
  import dmul_pkg::*;
#(
  parameter int unsigned IN_W  = EXT_W,
  parameter int unsigned OUT_W = 2 * IN_W - 1
) (
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  output logic [OUT_W-1:0] p_o
);

  localparam int unsigned PAD = OUT_W - IN_W;

  logic signed [OUT_W-1:0] a_w;
  logic signed [OUT_W-1:0] b_w;

  // Inputs are already widened two's complement values. Sign-extend them
  // to the product width so the truncated product is exact.
  assign a_w = {{PAD{a_i[IN_W-1]}}, a_i};
  assign b_w = {{PAD{b_i[IN_W-1]}}, b_i};
  assign p_o = a_w * b_w;

endmodule

// File: rtl/dmul_scale.sv
module dmul_scale
  import dmul_pkg::*;
#(
  parameter int unsigned P_W = PROD_W,
  parameter int unsigned A_W = ACC_W,
  parameter int unsigned H_W = (P_W - 1) / 2
) (
  input  logic [P_W-1:0] prod_i,
  input  logic           frac_i,
  input  logic           byte_i,
  input  logic           both_signed_i,
  output logic [A_W-1:0] res_o
);

  localparam int unsigned SEXT = A_W - P_W;
  // (-1.0) * (-1.0) gives 2^(2*H_W-2), the only overflowing Q31 case
  localparam logic [P_W-1:0] SAT_HIT = P_W'(1) << (2 * H_W - 2);
  localparam logic [A_W-1:0] Q_MAX   = (A_W'(1) << (2 * H_W - 1)) - A_W'(1);

  logic [P_W-1:0] scaled;
  logic           sat_case;

  assign scaled   = {prod_i[P_W-2:0], 1'b0};
  assign sat_case = both_signed_i && (prod_i == SAT_HIT);

  always_comb begin
    if (byte_i) begin
      res_o = {{(A_W - H_W){1'b0}}, prod_i[H_W-1:0]};
    end else if (frac_i) begin
      if (sat_case) begin
        res_o = Q_MAX;
      end else begin
        res_o = {{SEXT{scaled[P_W-1]}}, scaled};
      end
    end else begin
      res_o = {{SEXT{prod_i[P_W-1]}}, prod_i};
    end
  end

endmodule

// File: rtl/dmul_unit.sv
module dmul_unit
  import dmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mul_en,
  input  logic [OP_W-1:0]   opnd_a,
  input  logic [OP_W-1:0]   opnd_b,
  input  logic              a_is_signed,
  input  logic              b_is_signed,
  input  logic              frac_sel,
  input  logic              byte_sel,
  output logic              acc_vld,
  output logic [ACC_W-1:0]  acc_out
);

  localparam int unsigned N_OPS = 2;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Operand widening, one extender per operand
  opnd_t [N_OPS-1:0] ops;
  ext_t  [N_OPS-1:0] exts;
  logic  [N_OPS-1:0] sgn;

  assign ops = {opnd_b, opnd_a};
  assign sgn = {b_is_signed, a_is_signed};

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_ext
    dmul_opext #(
      .IN_W  (OP_W),
      .OUT_W (EXT_W),
      .LO_W  (BYTE_W)
    ) u_ext (
      .op_i     (ops[gi]),
      .signed_i (sgn[gi]),
      .byte_i   (byte_sel),
      .ext_o    (exts[gi])
    );
  end

  prod_t prod;
  acc_t  res;

  dmul_array #(
    .IN_W  (EXT_W),
    .OUT_W (PROD_W)
  ) u_array (
    .a_i (exts[0]),
    .b_i (exts[1]),
    .p_o (prod)
  );

  dmul_scale #(
    .P_W (PROD_W),
    .A_W (ACC_W),
    .H_W (OP_W)
  ) u_scale (
    .prod_i        (prod),
    .frac_i        (frac_sel),
    .byte_i        (byte_sel),
    .both_signed_i (&sgn),
    .res_o         (res)
  );

  // Next-state logic
  logic vld_nxt;
  acc_t acc_nxt;

  always_comb begin
    vld_nxt = mul_en;
    acc_nxt = acc_out;
    if (mul_en) begin
      acc_nxt = res;
    end
  end

  // Result register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_vld <= 1'b0;
      acc_out <= '0;
    end else begin
      acc_vld <= vld_nxt;
      acc_out <= acc_nxt;
    end
  end

endmodule

// File: rtl/dmul_unit_chk.sv
module dmul_unit_chk
  import dmul_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             mul_en,
  input logic [OP_W-1:0]  opnd_a,
  input logic [OP_W-1:0]  opnd_b,
  input logic             a_is_signed,
  input logic             b_is_signed,
  input logic             frac_sel,
  input logic             byte_sel,
  input logic             acc_vld,
  input logic [ACC_W-1:0] acc_out
);

  localparam logic [OP_W-1:0]  NEG_ONE = OP_W'(1) << (OP_W - 1);
  localparam logic [ACC_W-1:0] Q_MAX   = (ACC_W'(1) << (2 * OP_W - 1)) - ACC_W'(1);

  logic sat_in;
  assign sat_in = mul_en && frac_sel && !byte_sel && a_is_signed && b_is_signed &&
                  (opnd_a == NEG_ONE) && (opnd_b == NEG_ONE);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!acc_vld && acc_out == '0));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_vld == $past(mul_en));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(mul_en) |-> $stable(acc_out));

  // R6
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_vld && $past(byte_sel)) |-> (acc_out[ACC_W-1:OP_W] == '0));

  // R11
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_vld && !$past(byte_sel)) |->
      (acc_out[ACC_W-1:2*OP_W] == '0 || acc_out[ACC_W-1:2*OP_W] == '1));

  // R5
  q31_sat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(sat_in) |-> (acc_out == Q_MAX));

  // R4
  frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_vld && $past(frac_sel && !byte_sel)) |-> (!acc_out[0] || acc_out == Q_MAX));

endmodule

bind dmul_unit dmul_unit_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .mul_en      (mul_en),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .a_is_signed (a_is_signed),
  .b_is_signed (b_is_signed),
  .frac_sel    (frac_sel),
  .byte_sel    (byte_sel),
  .acc_vld     (acc_vld),
  .acc_out     (acc_out)
);

// File: tb/dmul_unit_test.sv
module dmul_unit_test;

  logic        clk;
  logic        rst_n;
  logic        mul_en;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic        a_is_signed;
  logic        b_is_signed;
  logic        frac_sel;
  logic        byte_sel;
  logic        acc_vld;
  logic [39:0] acc_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  dmul_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mul_en      (mul_en),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .a_is_signed (a_is_signed),
    .b_is_signed (b_is_signed),
    .frac_sel    (frac_sel),
    .byte_sel    (byte_sel),
    .acc_vld     (acc_vld),
    .acc_out     (acc_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {a, b, {a_signed, b_signed, frac, byte}, expected}
  localparam int NV = 16;
  localparam logic [75:0] VEC [NV] = '{
    {16'h0003, 16'h0004, 4'b1100, 40'h00_0000_000C}, // R2 small
    {16'hFFFF, 16'h0001, 4'b1100, 40'hFF_FFFF_FFFF}, // R1 signed fill
    {16'hFFFF, 16'h0001, 4'b0000, 40'h00_0000_FFFF}, // R1 zero fill
    {16'hFFFF, 16'hFFFF, 4'b0000, 40'h00_FFFE_0001}, // R2 R11 unsigned max
    {16'hFFFF, 16'hFFFF, 4'b1000, 40'hFF_FFFF_0001}, // R3 mixed
    {16'h8000, 16'hFFFF, 4'b1000, 40'hFF_8000_8000}, // R3 mixed extreme
    {16'h4000, 16'h4000, 4'b1110, 40'h00_2000_0000}, // R4 0.5*0.5
    {16'h8000, 16'h4000, 4'b1110, 40'hFF_C000_0000}, // R4 -1*0.5
    {16'h8000, 16'h8000, 4'b1110, 40'h00_7FFF_FFFF}, // R5 saturate
    {16'h7FFF, 16'h7FFF, 4'b1110, 40'h00_7FFE_0002}, // R4 largest legal
    {16'h8000, 16'h8000, 4'b0010, 40'h00_8000_0000}, // R5 unsigned no sat
    {16'h12FF, 16'h3402, 4'b1101, 40'h00_0000_FFFE}, // R6 R7 signed bytes
    {16'hAAFF, 16'h55FF, 4'b0001, 40'h00_0000_FE01}, // R7 unsigned bytes
    {16'h0080, 16'h0080, 4'b1111, 40'h00_0000_4000}, // R6 frac ignored
    {16'h0080, 16'h00FF, 4'b1001, 40'h00_0000_8080}, // R3 R6 mixed bytes
    {16'h8000, 16'hFFFF, 4'b1010, 40'hFF_0001_0000}  // R3 R4 mixed frac
  };

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [3:0] m,
                       input logic en);
    opnd_a      = a;
    opnd_b      = b;
    a_is_signed = m[3];
    b_is_signed = m[2];
    frac_sel    = m[1];
    byte_sel    = m[0];
    mul_en      = en;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(16'h0, 16'h0, 4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset acc_vld", {39'd0, acc_vld}, 40'd0);
    check("R10 reset acc_out", acc_out, 40'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: drive at a falling edge, sample at the next one
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][75:60], VEC[i][59:44], VEC[i][43:40], 1'b1);
      @(negedge clk);
      check($sformatf("R8 vector %0d valid", i), {39'd0, acc_vld}, 40'd1);
      check($sformatf("R1..R7 vector %0d result", i), acc_out, VEC[i][39:0]);
    end

    // R9: hold while disabled with changing inputs
    drive(16'h1234, 16'h0567, 4'b1100, 1'b0);
    @(negedge clk);
    check("R8 valid drops", {39'd0, acc_vld}, 40'd0);
    check("R9 hold", acc_out, 40'hFF_0001_0000);
    drive(16'h7FFF, 16'h8000, 4'b0011, 1'b0);
    @(negedge clk);
    check("R9 hold again", acc_out, 40'hFF_0001_0000);

    // R7: high bytes differ, same low bytes, same result
    drive(16'hFFFE, 16'h0003, 4'b1101, 1'b1);
    @(negedge clk);
    check("R7 upper bits ignored", acc_out, 40'h00_0000_FFFA);

    // R10: asynchronous clear mid-run
    drive(16'h0100, 16'h0100, 4'b0000, 1'b1);
    @(negedge clk);
    check("R2 load before reset", acc_out, 40'h00_0001_0000);
    #2 rst_n = 1'b0;
    #1;
    check("R10 async clear out", acc_out, 40'd0);
    check("R10 async clear vld", {39'd0, acc_vld}, 40'd0);
    finish_run();
  end

endmodule